// File: doc/BRIEF.md
# MII Transmit Timestamp Inserter

This block sits in line on the nibble-wide transmit path between an Ethernet MAC and its PHY. Every nibble, with its enable and error strobes, goes through a fixed nine-cycle pipeline. While a frame passes, the block finds the start-of-frame delimiter and reads the two-byte type field that follows the two six-byte addresses. If that type equals one configured value, the frame is a clock synchronization packet.

For such a packet, the block captures the local time bus in the cycle that carries the last type nibble. It writes that value over the first eight payload bytes while the frame is in flight. It then recomputes the CRC-32 over the modified frame and sends the new value in place of the old frame check sequence. The block finds the FCS with an eight-nibble look-ahead, so it needs no length field. Every other frame, and every burst with no delimiter, leaves the block bit for bit as it arrived.

A typical use is in a node that distributes time. The driver builds the packet with a placeholder field, and the block fills in the departure time as close to the wire as the MII allows.

Top module: `mii_tx_stamper`

## Requirements
- R1: While `rst_n` is low, `phy_txd`, `phy_txen` and `phy_txer` are all zero.
- R2: Every nibble and its enable appear at the PHY side exactly 9 clock cycles after they are presented on the MAC side, for every kind of frame.
- R3: The frame body begins with the nibble after the first nibble of value 0xD seen since `mac_txen` rose. Nibbles are taken least significant first, so the delimiter byte 0xD5 ends in nibble 0xD. Any number of preamble nibbles is accepted, and 0xD nibbles later in the frame do not restart it.
- R4: A frame is a clock synchronization packet only when body bytes 12 and 13 equal `CSP_TYPE[15:8]` and `CSP_TYPE[7:0]` in that order. A type differing in one bit, or with its bytes swapped, is not one.
- R5: A frame that is not a clock synchronization packet, including a burst with no delimiter, leaves the block unchanged, FCS included.
- R6: In a clock synchronization packet, body bytes 14 to 21 are replaced by the value of `time_now` in the cycle in which body nibble 27 was presented. The most significant byte comes first, and each byte is sent low nibble first.
- R7: In a clock synchronization packet, every byte after the timestamp field and before the FCS is forwarded unchanged.
- R8: In a clock synchronization packet, the last four bytes carry a fresh CRC-32 over the modified body up to the FCS. The CRC uses polynomial 0x04C11DB7, a preset of all ones, reflected input and a complemented result, and is sent least significant byte first. The CRC register run over the whole outgoing body therefore ends at 0xDEBB20E3.
- R9: `mac_txer` is forwarded with the same 9-cycle delay as the data and is never altered.
- R10: Frames separated by a single idle cycle are each handled correctly, including their FCS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MII transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mac_txd | input | 4 | Data nibble from the MAC |
| mac_txen | input | 1 | Frame enable from the MAC |
| mac_txer | input | 1 | Error strobe from the MAC |
| time_now | input | TS_W | Local time value, sampled for stamping |
| phy_txd | output | 4 | Data nibble to the PHY |
| phy_txen | output | 1 | Delayed frame enable to the PHY |
| phy_txer | output | 1 | Delayed error strobe to the PHY |

## Verification
Stamped and plain frames are each swept over preamble lengths of one to seven bytes. This shows that delimiter detection is independent of the preamble length, and that the addresses (which contain 0xD nibbles) never restart it. Near-miss types (one bit off, bytes swapped) and a burst with no delimiter separate true matches from look-alikes, and their output must equal their input exactly. Stamped frames are checked in three regions: the timestamp bytes against the time value of the sampling cycle, the untouched tail, and the new FCS, which is checked both by recomputation and by the CRC residue. Two frames sent one idle cycle apart, one carrying an error nibble, test the look-ahead FCS detection at its tightest spacing.

// File: rtl/mii_ts_pkg.sv
package mii_ts_pkg;

    localparam int NIB_W   = 4;
    localparam int CRC_W   = 32;
    localparam int FCS_NIB = CRC_W / NIB_W;
    localparam logic [NIB_W-1:0] SFD_NIB = 4'hD;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;

    typedef struct packed {
        logic [NIB_W-1:0] dat;
        logic             en;
        logic             er;
        logic             body;
        logic             csp;
    } nib_t;

    // advance a reflected CRC-32 register by one nibble, lsb first
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c_in,
                                                  input logic [NIB_W-1:0] n_in);
        logic [CRC_W-1:0] c;
        c = c_in;
        for (int i = 0; i < NIB_W; i++) begin
            if (c[0] ^ n_in[i]) c = (c >> 1) ^ CRC_POLY_REFL;
            else                c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/mii_ts_parse.sv
module mii_ts_parse
    import mii_ts_pkg::*;
#(
    parameter int          TS_W       = 64,
    parameter logic [15:0] CSP_TYPE   = 16'h88B5,
    parameter int          ADDR_BYTES = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] d_i,
    input  logic             en_i,
    input  logic             er_i,
    input  logic [TS_W-1:0]  time_i,
    output nib_t             nib_o
);

    localparam int TS_NIB   = TS_W / NIB_W;
    localparam int TYPE_POS = 4 * ADDR_BYTES;
    localparam int TS_POS   = TYPE_POS + 4;
    localparam int TS_END   = TS_POS + TS_NIB;
    localparam int CW       = $clog2(TS_END + 1);
    localparam int IW       = $clog2(TS_W);

    localparam logic [CW-1:0] C_T0  = CW'(TYPE_POS);
    localparam logic [CW-1:0] C_T1  = CW'(TYPE_POS + 1);
    localparam logic [CW-1:0] C_T2  = CW'(TYPE_POS + 2);
    localparam logic [CW-1:0] C_T3  = CW'(TYPE_POS + 3);
    localparam logic [CW-1:0] C_TS0 = CW'(TS_POS);
    localparam logic [CW-1:0] C_TSE = CW'(TS_END);

    typedef enum logic [1:0] {PS_IDLE, PS_PRE, PS_BODY} pstate_t;

    typedef struct packed {
        pstate_t         st;
        logic [CW-1:0]   cnt;
        logic [11:0]     typ;
        logic            csp;
        logic [TS_W-1:0] ts;
    } pars_t;

    pars_t         par_q, par_d;
    logic [CW-1:0] rel_n;
    logic [CW-1:0] rel_b;
    logic [IW-1:0] sel_lsb;

    always_comb begin
        par_d      = par_q;
        nib_o.dat  = d_i;
        nib_o.en   = en_i;
        nib_o.er   = er_i;
        nib_o.body = 1'b0;
        nib_o.csp  = 1'b0;
        rel_n      = par_q.cnt - C_TS0;
        rel_b      = rel_n >> 1;
        sel_lsb    = IW'(TS_W - 8 - 8 * int'(rel_b) + (rel_n[0] ? 4 : 0));

        if (!en_i) begin
            par_d.st  = PS_IDLE;
            par_d.cnt = '0;
            par_d.csp = 1'b0;
        end else if (par_q.st == PS_BODY) begin
            nib_o.body = 1'b1;
            nib_o.csp  = par_q.csp;
            if (par_q.cnt != C_TSE) par_d.cnt = par_q.cnt + 1'b1;
            if (par_q.cnt == C_T0) par_d.typ[7:4]  = d_i;
            if (par_q.cnt == C_T1) par_d.typ[11:8] = d_i;
            if (par_q.cnt == C_T2) par_d.typ[3:0]  = d_i;
            if (par_q.cnt == C_T3 && {par_q.typ[11:4], d_i, par_q.typ[3:0]} == CSP_TYPE) begin
                par_d.csp = 1'b1;
                par_d.ts  = time_i;
            end
            if (par_q.csp && par_q.cnt >= C_TS0 && par_q.cnt < C_TSE)
                nib_o.dat = par_q.ts[sel_lsb +: NIB_W];
        end else if (d_i == SFD_NIB) begin
            par_d.st  = PS_BODY;
            par_d.cnt = '0;
        end else begin
            par_d.st = PS_PRE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q <= '{st: PS_IDLE, cnt: '0, typ: '0, csp: 1'b0, ts: '0};
        end else begin
            par_q <= par_d;
        end
    end

    // R3
    sfd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_o.body && !$past(nib_o.body)) |-> ($past(d_i) == SFD_NIB && $past(en_i)));

    // R5
    plain_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nib_o.csp |-> (nib_o.dat == d_i));

    // R7
    tail_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_q.st == PS_BODY && par_q.cnt == C_TSE) |-> (nib_o.dat == d_i));

endmodule

// File: rtl/mii_ts_delay.sv
module mii_ts_delay
    import mii_ts_pkg::*;
#(
    parameter int DEPTH = FCS_NIB
) (
    input  logic clk,
    input  logic rst_n,
    input  nib_t nib_i,
    output nib_t nib_o
);

    nib_t [DEPTH-1:0] line_q, line_d;

    always_comb begin
        line_d[0] = nib_i;
        for (int i = 1; i < DEPTH; i++) line_d[i] = line_q[i-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign nib_o = line_q[DEPTH-1];

endmodule

// File: rtl/mii_ts_fcs.sv
module mii_ts_fcs
    import mii_ts_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  nib_t             nib_i,
    input  logic             ahead_body_i,
    output logic [NIB_W-1:0] d_o,
    output logic             en_o,
    output logic             er_o
);

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic             tail;
        logic [NIB_W-1:0] dat;
        logic             en;
        logic             er;
    } fcs_t;

    fcs_t fcs_q, fcs_d;
    logic tail_now;

    always_comb begin
        fcs_d    = fcs_q;
        tail_now = nib_i.body && (!ahead_body_i || fcs_q.tail);
        fcs_d.tail = tail_now;
        fcs_d.en   = nib_i.en;
        fcs_d.er   = nib_i.er;
        fcs_d.dat  = nib_i.dat;
        if (!nib_i.body) begin
            fcs_d.crc = '1;
        end else if (!tail_now) begin
            fcs_d.crc = crc_step(fcs_q.crc, nib_i.dat);
        end else begin
            fcs_d.crc = {{NIB_W{1'b0}}, fcs_q.crc[CRC_W-1:NIB_W]};
            if (nib_i.csp) fcs_d.dat = ~fcs_q.crc[NIB_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fcs_q <= '{crc: '1, tail: 1'b0, dat: '0, en: 1'b0, er: 1'b0};
        else        fcs_q <= fcs_d;
    end

    assign d_o  = fcs_q.dat;
    assign en_o = fcs_q.en;
    assign er_o = fcs_q.er;

    // checker: the tail region spans exactly the FCS length
    logic [NIB_W:0] tail_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n)        tail_cnt_q <= '0;
        else if (tail_now) tail_cnt_q <= tail_cnt_q + 1'b1;
        else               tail_cnt_q <= '0;
    end

    // R8
    fcs_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fcs_q.tail && !nib_i.body) |-> (tail_cnt_q == (NIB_W+1)'(FCS_NIB)));

endmodule

// File: rtl/mii_tx_stamper.sv
module mii_tx_stamper
    import mii_ts_pkg::*;
#(
    parameter int          TS_W       = 64,
    parameter logic [15:0] CSP_TYPE   = 16'h88B5,
    parameter int          ADDR_BYTES = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       mac_txd,
    input  logic             mac_txen,
    input  logic             mac_txer,
    input  logic [TS_W-1:0]  time_now,
    output logic [3:0]       phy_txd,
    output logic             phy_txen,
    output logic             phy_txer
);

    localparam int LAT = FCS_NIB + 1;

    nib_t tag_in, tag_dly;

    mii_ts_parse #(.TS_W(TS_W), .CSP_TYPE(CSP_TYPE), .ADDR_BYTES(ADDR_BYTES)) u_parse (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_i    (mac_txd),
        .en_i   (mac_txen),
        .er_i   (mac_txer),
        .time_i (time_now),
        .nib_o  (tag_in)
    );

    mii_ts_delay #(.DEPTH(FCS_NIB)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .nib_i (tag_in),
        .nib_o (tag_dly)
    );

    mii_ts_fcs u_fcs (
        .clk          (clk),
        .rst_n        (rst_n),
        .nib_i        (tag_dly),
        .ahead_body_i (tag_in.body),
        .d_o          (phy_txd),
        .en_o         (phy_txen),
        .er_o         (phy_txer)
    );

    // checker: cycles since reset, saturating at the latency
    logic [4:0] settle_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                   settle_q <= '0;
        else if (settle_q != 5'(LAT)) settle_q <= settle_q + 1'b1;
    end

    // R2
    lat_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_q == 5'(LAT)) |-> (phy_txen == $past(mac_txen, LAT)));

    // R9
    lat_er_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_q == 5'(LAT)) |-> (phy_txer == $past(mac_txer, LAT)));

endmodule

// File: tb/mii_tx_stamper_bench.sv
module mii_tx_stamper_bench;

    localparam logic [15:0] CSP = 16'h88B5;
    localparam int MAXF = 32;
    localparam int MAXN = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mac_txd = '0;
    logic        mac_txen = 1'b0;
    logic        mac_txer = 1'b0;
    logic [63:0] time_now = '0;
    logic [3:0]  phy_txd;
    logic        phy_txen;
    logic        phy_txer;

    always #2.5 clk = ~clk;

    mii_tx_stamper u_mii_tx_stamper (
        .clk(clk), .rst_n(rst_n), .mac_txd(mac_txd), .mac_txen(mac_txen),
        .mac_txer(mac_txer), .time_now(time_now), .phy_txd(phy_txd),
        .phy_txen(phy_txen), .phy_txer(phy_txer)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] fb [0:MAXN-1];
    logic [3:0] exp_n [0:MAXF-1][0:MAXN-1];
    logic       exp_e [0:MAXF-1][0:MAXN-1];
    logic [3:0] got_n [0:MAXF-1][0:MAXN-1];
    logic       got_e [0:MAXF-1][0:MAXN-1];
    int exp_len [0:MAXF-1];
    int got_len [0:MAXF-1];
    int in_start [0:MAXF-1];
    int out_start [0:MAXF-1];
    int fr_pre [0:MAXF-1];
    bit fr_csp [0:MAXF-1];
    bit fr_tight [0:MAXF-1];
    logic [63:0] fr_ts [0:MAXF-1];
    int nfr = 0;
    int fr_out = -1;
    logic prev_en = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] crc_byte(input logic [31:0] c_in, input logic [7:0] b);
        logic [31:0] c;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ b[i]) c = (c >> 1) ^ 32'hEDB88320;
            else             c = c >> 1;
        end
        return c;
    endfunction

    always @(negedge clk) begin
        if (phy_txen) begin
            if (!prev_en) begin
                fr_out = fr_out + 1;
                out_start[fr_out] = cyc;
                got_len[fr_out] = 0;
            end
            got_n[fr_out][got_len[fr_out]] = phy_txd;
            got_e[fr_out][got_len[fr_out]] = phy_txer;
            got_len[fr_out] = got_len[fr_out] + 1;
        end
        prev_en = phy_txen;
    end

    task automatic drive(input logic [3:0] dv, input logic ev, input logic erv);
        @(negedge clk);
        mac_txd  = dv;
        mac_txen = ev;
        mac_txer = erv;
        time_now = {32'(cyc) * 32'h9E3779B9, 32'(cyc) ^ 32'h5A5A0F0F};
    endtask

    task automatic send(input int pre, input logic [15:0] typ, input int plen,
                        input int err_n, input int gap, input bit raw, input bit tight);
        int n;
        int f;
        int body0;
        logic [31:0] c;
        logic [63:0] ts;
        bit csp;
        f = nfr;
        nfr = nfr + 1;
        n = 0;
        ts = '0;
        for (int i = 0; i < pre; i++) begin fb[n] = 8'h55; n = n + 1; end
        body0 = n + 1;
        if (!raw) begin
            fb[n] = 8'hD5; n = n + 1;
            for (int i = 0; i < 6; i++) begin fb[n] = (i % 2 == 0) ? 8'hD5 : 8'h5D; n = n + 1; end
            for (int i = 0; i < 6; i++) begin fb[n] = 8'(8'h10 + i * 17 + f); n = n + 1; end
            fb[n] = typ[15:8]; n = n + 1;
            fb[n] = typ[7:0];  n = n + 1;
            for (int i = 0; i < plen; i++) begin fb[n] = 8'(i * 37 + f * 11 + 3); n = n + 1; end
            c = 32'hFFFFFFFF;
            for (int i = body0; i < n; i++) c = crc_byte(c, fb[i]);
            c = ~c;
            for (int i = 0; i < 4; i++) begin fb[n] = c[8*i +: 8]; n = n + 1; end
        end
        for (int j = 0; j < 2 * n; j++) begin
            drive(j[0] ? fb[j/2][7:4] : fb[j/2][3:0], 1'b1, j == err_n);
            if (j == 0) in_start[f] = cyc;
            if (!raw && j == 2 * body0 + 27) ts = time_now;
            exp_e[f][j] = (j == err_n);
        end
        for (int g = 0; g < gap; g++) drive(4'h0, 1'b0, 1'b0);
        csp = !raw && (typ == CSP);
        if (csp) begin
            for (int k = 0; k < 8; k++) fb[body0 + 14 + k] = ts[63 - 8*k -: 8];
            c = 32'hFFFFFFFF;
            for (int i = body0; i < n - 4; i++) c = crc_byte(c, fb[i]);
            c = ~c;
            for (int i = 0; i < 4; i++) fb[n - 4 + i] = c[8*i +: 8];
        end
        for (int j = 0; j < 2 * n; j++) exp_n[f][j] = j[0] ? fb[j/2][7:4] : fb[j/2][3:0];
        exp_len[f]  = 2 * n;
        fr_pre[f]   = pre;
        fr_csp[f]   = csp;
        fr_tight[f] = tight;
        fr_ts[f]    = ts;
    endtask

    function automatic logic [7:0] gbyte(input int f, input int k);
        return {got_n[f][2*k+1], got_n[f][2*k]};
    endfunction
    function automatic logic [7:0] ebyte(input int f, input int k);
        return {exp_n[f][2*k+1], exp_n[f][2*k]};
    endfunction

    task automatic verify(input int f);
        int nb;
        int b0;
        bit ok;
        logic [31:0] c;
        logic [63:0] gts;
        string rq;
        nb = exp_len[f] / 2;
        b0 = fr_pre[f] + 1;
        chk(got_len[f] == exp_len[f], "R2", "frame length", 64'(got_len[f]), 64'(exp_len[f]));
        chk(out_start[f] - in_start[f] == 9, "R2", "latency", 64'(out_start[f] - in_start[f]), 64'd9);
        if (got_len[f] != exp_len[f]) return;
        ok = 1'b1;
        for (int j = 0; j < 2 * (b0 + 14); j++) if (got_n[f][j] !== exp_n[f][j]) ok = 1'b0;
        chk(ok, "R3", "preamble and header", 64'(f), 64'(f));
        ok = 1'b1;
        for (int j = 0; j < exp_len[f]; j++) if (got_e[f][j] !== exp_e[f][j]) ok = 1'b0;
        chk(ok, "R9", "error strobe", 64'(f), 64'(f));
        if (fr_csp[f]) begin
            gts = '0;
            for (int k = 0; k < 8; k++) gts[63 - 8*k -: 8] = gbyte(f, b0 + 14 + k);
            chk(gts == fr_ts[f], "R6", "timestamp", gts, fr_ts[f]);
            ok = 1'b1;
            for (int k = b0 + 22; k < nb - 4; k++) if (gbyte(f, k) !== ebyte(f, k)) ok = 1'b0;
            chk(ok, "R7", "reserved tail", 64'(f), 64'(f));
            rq = fr_tight[f] ? "R10" : "R8";
            chk({gbyte(f, nb-1), gbyte(f, nb-2), gbyte(f, nb-3), gbyte(f, nb-4)} ==
                {ebyte(f, nb-1), ebyte(f, nb-2), ebyte(f, nb-3), ebyte(f, nb-4)}, rq, "new FCS",
                64'({gbyte(f, nb-1), gbyte(f, nb-2), gbyte(f, nb-3), gbyte(f, nb-4)}),
                64'({ebyte(f, nb-1), ebyte(f, nb-2), ebyte(f, nb-3), ebyte(f, nb-4)}));
            c = 32'hFFFFFFFF;
            for (int k = b0; k < nb; k++) c = crc_byte(c, gbyte(f, k));
            chk(c == 32'hDEBB20E3, "R8", "CRC residue", 64'(c), 64'h00000000DEBB20E3);
        end else begin
            ok = 1'b1;
            for (int j = 0; j < exp_len[f]; j++) if (got_n[f][j] !== exp_n[f][j]) ok = 1'b0;
            // R4 near-miss types and R5 pass-through share this comparison
            chk(ok, "R5", "unmodified frame (R4 near misses)", 64'(f), 64'(f));
        end
    endtask

    initial begin
        repeat (4) drive(4'h0, 1'b0, 1'b0);
        // R1
        chk(phy_txd == 4'h0 && phy_txen == 1'b0 && phy_txer == 1'b0, "R1", "reset outputs",
            64'({phy_txd, phy_txen, phy_txer}), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) drive(4'h0, 1'b0, 1'b0);
        // R3 sweep: preamble lengths 1..7, stamped and plain
        for (int p = 1; p <= 7; p++) begin
            send(p, CSP, 46, -1, 12, 1'b0, 1'b0);
            send(p, 16'h0800, 46, -1, 12, 1'b0, 1'b0);
        end
        // R4 near misses
        send(7, 16'h88B4, 46, -1, 12, 1'b0, 1'b0);
        send(7, 16'hB588, 46, -1, 12, 1'b0, 1'b0);
        // R5 burst with no delimiter
        send(10, CSP, 0, -1, 12, 1'b1, 1'b0);
        // R9 and R10: error nibble, then single idle cycle between frames
        send(7, CSP, 60, 70, 1, 1'b0, 1'b1);
        send(2, CSP, 47, -1, 1, 1'b0, 1'b1);
        send(3, 16'h0806, 50, 33, 20, 1'b0, 1'b1);
        repeat (20) drive(4'h0, 1'b0, 1'b0);
        chk(fr_out + 1 == nfr, "R2", "frame count", 64'(fr_out + 1), 64'(nfr));
        for (int f = 0; f < nfr && f <= fr_out; f++) verify(f);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule